// File: doc/BRIEF.md
# SPI Dual-Buffer Data Register

This block is the data-path front end of an SPI controller. A single bus address leads to two separate storage words. A write to that address fills a transmit holding buffer. A read from the same address returns the receive holding buffer. The value just written never comes back on a read. A second address returns status: a transmit-empty flag, a receive-full flag and a sticky overrun flag. Software polls these flags to pace its writes and reads.

A small full-duplex shift engine is included so that both buffers are actually exercised. When the controller is enabled and the transmit buffer is loaded, the engine copies that word into a shift register. It then clocks the word out MSB first with idle-low clock timing, and at the same time collects the incoming bits. The finished frame is placed in the receive buffer.

The frame width is either 8 or 16 bits. The width select is captured only while the controller is disabled, so changing it during operation has no effect until the next disable.

Top module: `spi_dbuf_top`

## Requirements
- R1: A bus write with `bus_addr`=0 loads the transmit buffer and drives `tx_empty` low on the next cycle. A bus read with `bus_addr`=0 returns the receive buffer and never the transmit buffer. Writes with `bus_addr`=1 have no effect.
- R2: After reset, a data read returns 0x0000, `tx_empty` is 1, `rx_full` is 0 and `overrun` is 0.
- R3: `wide_sel` (0 = 8-bit frames, 1 = 16-bit frames) is captured only in cycles where `enable` is 0. A change made while `enable` is 1 has no effect on frames.
- R4: In 8-bit mode only bits [7:0] of the written word are shifted out (8 clock pulses). A data read returns the received byte in bits [7:0] with bits [15:8] equal to zero, even when the input line was held high.
- R5: In 16-bit mode all 16 bits are shifted out (16 clock pulses), and a data read returns all 16 received bits.
- R6: A frame starts only while `enable` is 1 and the transmit buffer holds data. At frame start the buffer word moves into the shifter and `tx_empty` returns to 1.
- R7: A write made while a frame is running is kept in the transmit buffer (`tx_empty` stays 0) until the running frame has been delivered. After that it is sent as the next frame.
- R8: `rx_full` rises when a finished frame is placed in the receive buffer, and falls after a data read.
- R9: If a frame finishes while `rx_full` is 1, the receive buffer is overwritten and `overrun` is set. `overrun` is cleared only by a status read that follows a data read. A status read alone leaves it set.
- R10: `sclk` idles low. `mosi` changes only after falling edges of `sclk`, `miso` is sampled on rising edges, and bits go MSB first. Each half period of `sclk` lasts `SCK_HALF` system clocks.
- R11: Bus read data appears on `bus_rdata` in the cycle after `bus_rd`. A status read (`bus_addr`=1) returns `rx_full` in bit 0, `tx_empty` in bit 1, `overrun` in bit 2, and zeros in the other bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; frames run only while high |
| wide_sel | input | 1 | Frame width request, 0 = 8-bit, 1 = 16-bit |
| bus_addr | input | 1 | 0 = data word, 1 = status word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tx_empty | output | 1 | Transmit buffer holds no pending word |
| rx_full | output | 1 | Receive buffer holds an unread frame |
| overrun | output | 1 | Sticky receive overrun flag |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
On every cycle, the assertions check the handshakes between the pieces. The shifter takes a word only when the buffer is full. A write always fills the buffer, and a frame landing on a full receive buffer always raises overrun. They also check that `sclk` is low when idle, that `mosi` holds still across rising clock edges, and that the captured width never changes while enabled. Only the bench scenarios can show the end-to-end data values: MSB-first order, masking of the upper byte in 8-bit mode, the read-then-status order needed to clear overrun, and a queued write waiting behind a running frame.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  typedef enum logic {
    FRM_8  = 1'b0,
    FRM_16 = 1'b1
  } frame_t;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/spi_txbuf.sv
module spi_txbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] buf_data,
  output logic              empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_data <= '0;
      empty    <= 1'b1;
    end else begin
      if (take) empty <= 1'b1;
      if (wr_en) begin
        buf_data <= wr_data;
        empty    <= 1'b0;
      end
    end
  end

  assert_take_only_full_R6: assert property (@(posedge clk) disable iff (rst)
    take |-> !empty);
  assert_write_fills_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !empty);
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W   = 16,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wide,
  input  logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              take,
  output logic              sclk,
  output logic              mosi,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int CNT_W  = $clog2(SCK_HALF + 1);

  logic              busy;
  logic              frm_wide;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [CNT_W-1:0]  div_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BIT_W-1:0]  last_bit;

  assign take     = enable && tx_ready && !busy;
  assign mosi     = busy & tx_sh[DATA_W-1];
  assign last_bit = frm_wide ? BIT_W'(DATA_W - 1) : BIT_W'(BYTE_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      frm_wide <= 1'b0;
      sclk     <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      div_cnt  <= '0;
      bit_cnt  <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!busy) begin
        if (take) begin
          busy     <= 1'b1;
          frm_wide <= wide;
          sclk     <= 1'b0;
          div_cnt  <= '0;
          bit_cnt  <= '0;
          rx_sh    <= '0;
          tx_sh    <= wide ? tx_data : {tx_data[BYTE_W-1:0], {(DATA_W-BYTE_W){1'b0}}};
        end
      end else if (div_cnt == CNT_W'(SCK_HALF - 1)) begin
        div_cnt <= '0;
        sclk    <= ~sclk;
        if (!sclk) begin
          rx_sh <= {rx_sh[DATA_W-2:0], miso};
        end else if (bit_cnt == last_bit) begin
          busy     <= 1'b0;
          rx_valid <= 1'b1;
          rx_data  <= frm_wide ? rx_sh : {{(DATA_W-BYTE_W){1'b0}}, rx_sh[BYTE_W-1:0]};
        end else begin
          tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  assert_sclk_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  assert_mosi_steady_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
  assert_done_ends_frame_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> !busy);
endmodule

// File: rtl/spi_rxbuf.sv
module spi_rxbuf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_frame,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] buf_data,
  output logic              full,
  output logic              ovr
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_data <= '0;
      full     <= 1'b0;
      ovr      <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (rx_valid) begin
        buf_data <= rx_frame;
        full     <= 1'b1;
      end else if (data_rd) begin
        full <= 1'b0;
      end

      if (rx_valid && full) ovr <= 1'b1;
      else if (stat_rd && armed) ovr <= 1'b0;

      if (data_rd && ovr) armed <= 1'b1;
      else if (stat_rd) armed <= 1'b0;
    end
  end

  assert_overrun_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && full) |=> ovr);
  assert_overrun_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (ovr && !armed && !data_rd) |=> ovr);
  assert_read_drains_R8: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !rx_valid) |=> !full);
  assert_frame_fills_R8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> full);
endmodule

// File: rtl/spi_dbuf_top.sv
module spi_dbuf_top #(
  parameter int DATA_W   = 16,
  parameter int SCK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wide_sel,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              overrun,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  import spi_dr_pkg::*;

  frame_t            frm_q;
  logic              data_wr, data_rd, stat_rd;
  logic              take, rx_valid;
  logic [DATA_W-1:0] tx_word, rx_frame, rx_word;

  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
  assign data_rd = bus_rd && (bus_addr == ADDR_DATA);
  assign stat_rd = bus_rd && (bus_addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (rst) frm_q <= FRM_8;
    else if (!enable) frm_q <= wide_sel ? FRM_16 : FRM_8;
  end

  spi_txbuf #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .wr_en(data_wr), .wr_data(bus_wdata),
    .take(take), .buf_data(tx_word), .empty(tx_empty)
  );

  spi_shifter #(.DATA_W(DATA_W), .SCK_HALF(SCK_HALF)) u_sh (
    .clk(clk), .rst(rst), .enable(enable), .wide(frm_q == FRM_16),
    .tx_ready(!tx_empty), .tx_data(tx_word), .miso(miso), .take(take),
    .sclk(sclk), .mosi(mosi), .rx_valid(rx_valid), .rx_data(rx_frame)
  );

  spi_rxbuf #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_frame(rx_frame),
    .data_rd(data_rd), .stat_rd(stat_rd), .buf_data(rx_word),
    .full(rx_full), .ovr(overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (data_rd) bus_rdata <= rx_word;
    else if (stat_rd) bus_rdata <= {{(DATA_W-3){1'b0}}, overrun, tx_empty, rx_full};
  end

  assert_width_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    $past(enable) |-> $stable(frm_q));
endmodule

// File: tb/spi_dbuf_top_tb.sv
module spi_dbuf_top_tb;
  localparam int CLK_T = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        enable = 1'b0, wide_sel = 1'b0;
  logic        bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        tx_empty, rx_full, overrun, sclk, mosi, miso;
  logic        loop_en = 1'b1, miso_drv = 1'b0;
  int          n_chk = 0, n_err = 0;
  logic [15:0] cap = '0;
  int          ncap = 0;

  always #(CLK_T/2) clk = ~clk;
  assign miso = loop_en ? mosi : miso_drv;

  always @(posedge sclk) begin
    cap  = {cap[14:0], mosi};
    ncap = ncap + 1;
  end

  spi_dbuf_top u_dut (
    .clk(clk), .rst(rst), .enable(enable), .wide_sel(wide_sel),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_empty(tx_empty),
    .rx_full(rx_full), .overrun(overrun), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_rx(input string req);
    int n = 0;
    while (!rx_full && n < 2000) begin @(negedge clk); n++; end
    chk(req, 16'(rx_full), 16'd1);
  endtask

  task automatic wait_txe(input string req);
    int n = 0;
    while (!tx_empty && n < 2000) begin @(negedge clk); n++; end
    chk(req, 16'(tx_empty), 16'd1);
  endtask

  task automatic set_mode(input logic w);
    @(negedge clk); enable = 1'b0; wide_sel = w;
    @(negedge clk); enable = 1'b1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R2 tx_empty", 16'(tx_empty), 16'd1);
    chk("R2 rx_full", 16'(rx_full), 16'd0);
    chk("R2 overrun", 16'(overrun), 16'd0);
    bus_read(1'b0, d); chk("R2 data reset", d, 16'h0000);
    bus_read(1'b1, d); chk("R11 status after reset", d, 16'h0002);
  endtask

  task automatic t_split();
    logic [15:0] d;
    bus_write(1'b1, 16'hFFFF);
    chk("R1 status write ignored", 16'(tx_empty), 16'd1);
    bus_write(1'b0, 16'h5A5A);
    chk("R1 tx_empty clears", 16'(tx_empty), 16'd0);
    bus_read(1'b0, d); chk("R1 read returns rx not tx", d, 16'h0000);
    bus_read(1'b1, d); chk("R11 status with pending tx", d, 16'h0000);
    ncap = 0;
    repeat (40) @(negedge clk);
    chk("R6 no frame while disabled", 16'(tx_empty), 16'd0);
    chk("R6 no clocks while disabled", 16'(ncap), 16'd0);
  endtask

  task automatic t_frame8();
    logic [15:0] d;
    bus_write(1'b0, 16'h3CA5);
    ncap = 0;
    @(negedge clk); enable = 1'b1;
    wait_txe("R6 tx_empty at frame start");
    wait_rx("R8 rx_full after frame");
    chk("R4 8 clock pulses", 16'(ncap), 16'd8);
    chk("R10 MSB first byte", {8'h00, cap[7:0]}, 16'h00A5);
    bus_read(1'b0, d); chk("R4 8-bit read", d, 16'h00A5);
    chk("R8 rx_full clears on read", 16'(rx_full), 16'd0);
  endtask

  task automatic t_miso_high();
    logic [15:0] d;
    loop_en = 1'b0; miso_drv = 1'b1;
    bus_write(1'b0, 16'h0000);
    wait_rx("R8 frame with miso high");
    bus_read(1'b0, d); chk("R4 upper byte forced zero", d, 16'h00FF);
    loop_en = 1'b1; miso_drv = 1'b0;
  endtask

  task automatic t_frame16();
    logic [15:0] d;
    set_mode(1'b1);
    ncap = 0;
    bus_write(1'b0, 16'hBEEF);
    wait_rx("R8 16-bit frame done");
    chk("R5 16 clock pulses", 16'(ncap), 16'd16);
    chk("R10 MSB first word", cap, 16'hBEEF);
    bus_read(1'b0, d); chk("R5 16-bit read", d, 16'hBEEF);
  endtask

  task automatic t_width_frozen();
    logic [15:0] d;
    @(negedge clk); wide_sel = 1'b0;
    bus_write(1'b0, 16'h1234);
    wait_rx("R3 frame done");
    bus_read(1'b0, d); chk("R3 width unchanged while enabled", d, 16'h1234);
    set_mode(1'b0);
    bus_write(1'b0, 16'h1234);
    wait_rx("R3 frame done after disable");
    bus_read(1'b0, d); chk("R3 width taken while disabled", d, 16'h0034);
  endtask

  task automatic t_hold();
    logic [15:0] d;
    int viol = 0, n = 0;
    bus_write(1'b0, 16'h0011);
    wait_txe("R7 first frame started");
    bus_write(1'b0, 16'h0022);
    chk("R7 queued write pending", 16'(tx_empty), 16'd0);
    while (!rx_full && n < 2000) begin
      if (tx_empty) viol++;
      @(negedge clk); n++;
    end
    chk("R7 queued word held during frame", 16'(viol), 16'd0);
    bus_read(1'b0, d); chk("R7 first frame data", d, 16'h0011);
    wait_rx("R7 second frame done");
    bus_read(1'b0, d); chk("R7 second frame data", d, 16'h0022);
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    int n = 0;
    bus_write(1'b0, 16'h0081);
    wait_txe("R9 first frame started");
    bus_write(1'b0, 16'h0042);
    while (!overrun && n < 2000) begin @(negedge clk); n++; end
    chk("R9 overrun set", 16'(overrun), 16'd1);
    bus_read(1'b1, d); chk("R11 status with overrun", d, 16'h0007);
    chk("R9 status read alone keeps overrun", 16'(overrun), 16'd1);
    bus_read(1'b0, d); chk("R9 overwritten data", d, 16'h0042);
    bus_read(1'b1, d); chk("R9 status after data read", d, 16'h0006);
    chk("R9 overrun cleared", 16'(overrun), 16'd0);
  endtask

  initial begin
    #(CLK_T * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_split();
    t_frame8();
    t_miso_high();
    t_frame16();
    t_width_frozen();
    t_hold();
    t_overrun();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule